// File: doc/BRIEF.md
# Streaming Overlap-Add Segment Scheduler

This block feeds a pair of external transform paths in a block-based convolution engine and rebuilds one continuous output stream from what they return. Incoming samples are cut into segments of `SEG_LEN` samples. Even segments go to path 0 and odd segments to path 1. Each sample of a segment is forwarded to its path in the cycle it is accepted. When a segment is complete, the same path gets `SEG_LEN` zero beats on its own, one per cycle. Every path therefore sees frames of `2*SEG_LEN` points, and a channel response no longer than `SEG_LEN` taps gives a full linear convolution without wrap-around.

While a path is still taking the zero tail of one segment, the other path takes the samples of the next segment, so the input stream never has to wait.

Each path returns `2*SEG_LEN` result beats per frame. The first half of a result is its head and the second half is its tail. The tail is parked in an overlap store of `SEG_LEN` slots. The next result's head is added slot by slot to the parked tail. A head beat is only taken when the matching tail beat is already parked or is arriving in the same cycle, so the adder never combines a sample with a missing partner. After reset every slot holds zero, so the first output segment is the first head on its own. The returned paths may have any fixed latency, including a full frame.

Top module: `ola_sched`

## Requirements
- R1: After reset, `out_valid` is 0, `fr_valid` is 0, `in_ready` is 1 and `seg_sel` is 0.
- R2: An accepted input sample appears in the same cycle on the frame lane selected by `seg_sel`. Lane p occupies bits `[p*DATA_W +: DATA_W]` of `fr_data`. `fr_start[p]` is 1 exactly on the first sample of each segment.
- R3: `seg_sel` starts at 0 and flips after every `SEG_LEN` accepted samples. Segment k therefore goes to path k mod 2.
- R4: Starting the cycle after a segment's last sample, its path receives exactly `SEG_LEN` zero-valued beats on consecutive cycles, without `fr_start`.
- R5: Output sample n equals the linear convolution of the input stream with the paths' impulse response. It is formed as the head beat j of result k plus the tail beat j of result k-1, where n = k*`SEG_LEN` + j.
- R6: After reset the overlap store holds zeros, so the first `SEG_LEN` outputs equal the first result's head alone.
- R7: With both paths at the same fixed latency, from 1 up to `2*SEG_LEN` cycles, every returned beat is accepted in the cycle it is presented (`ret_ready` is high whenever `ret_valid` is high).
- R8: Idle cycles in the input stream (`in_valid` low) do not change any output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Scheduler can take a sample |
| in_data | input | DATA_W | Signed input sample |
| seg_sel | output | 1 | Path currently receiving segment samples |
| fr_valid | output | 2 | Frame beat valid, one bit per path |
| fr_start | output | 2 | First beat of a frame, one bit per path |
| fr_data | output | 2*DATA_W | Frame beat data, one lane per path |
| ret_valid | input | 2 | Result beat present, one bit per path |
| ret_ready | output | 2 | Result beat taken, one bit per path |
| ret_data | input | 2*RES_W | Signed result beats, one lane per path |
| out_valid | output | 1 | Output sample valid |
| out_data | output | RES_W+1 | Signed overlap-added output sample |

## Verification
The bench builds the scheduler with `SEG_LEN` = 8, `DATA_W` = 12 and `RES_W` = 24. With these values each run is a five-segment stream, short enough to compare every output sample against a directly computed 8-tap convolution, including full-scale input extremes. The short frame also lets the path stubs sweep latencies of 1, 3, 7 and the full 16-cycle frame. Both a gap-free input stream and one with regular idle cycles are used.

// File: rtl/ola_pkg.sv
package ola_pkg;

  // Path identifiers for the two transform lanes.
  localparam logic PATH_EVEN = 1'b0;
  localparam logic PATH_ODD  = 1'b1;

  // True on the final beat index of a run of len beats.
  function automatic logic is_last(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

endpackage

// File: rtl/seg_sched.sv
module seg_sched #(
  parameter int SEG_LEN = 128,
  parameter int DATA_W  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  output logic                seg_sel,
  output logic [1:0]          fr_valid,
  output logic [1:0]          fr_start,
  output logic [2*DATA_W-1:0] fr_data
);
  localparam int CW = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;

  logic          sel;
  logic [CW-1:0] seg_cnt;
  logic [1:0]    pad_act;
  logic [CW-1:0] pad_cnt [2];

  // named events for the checks below
  logic in_fire;
  logic seg_last;

  assign in_ready = ~pad_act[sel];
  assign in_fire  = in_valid & in_ready;
  assign seg_last = in_fire & ola_pkg::is_last(int'(seg_cnt), SEG_LEN);
  assign seg_sel  = sel;

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      fr_valid[p] = pad_act[p] | (in_fire & (sel == 1'(p)));
      fr_start[p] = in_fire & (sel == 1'(p)) & (seg_cnt == '0);
      fr_data[p*DATA_W +: DATA_W] = (in_fire & (sel == 1'(p))) ? in_data : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= ola_pkg::PATH_EVEN;
      seg_cnt <= '0;
      pad_act <= '0;
      for (int p = 0; p < 2; p++) pad_cnt[p] <= '0;
    end else begin
      if (in_fire) seg_cnt <= seg_last ? '0 : seg_cnt + 1'b1;
      if (seg_last) sel <= ~sel;
      for (int p = 0; p < 2; p++) begin
        if (seg_last && sel == 1'(p)) begin
          pad_act[p] <= 1'b1;
          pad_cnt[p] <= '0;
        end else if (pad_act[p]) begin
          pad_cnt[p] <= pad_cnt[p] + 1'b1;
          if (ola_pkg::is_last(int'(pad_cnt[p]), SEG_LEN)) pad_act[p] <= 1'b0;
        end
      end
    end
  end

  AST_SEL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    seg_last |=> (sel != $past(sel)));  // R3

  AST_PAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    seg_last |=> pad_act[$past(sel)]);  // R4

  for (genvar p = 0; p < 2; p++) begin : g_chk
    AST_PAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pad_act[p]) |-> ($past(pad_cnt[p]) == CW'(SEG_LEN - 1)));  // R4
    AST_START_IS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      fr_start[p] |-> (fr_valid[p] && !pad_act[p] && seg_sel == 1'(p)));  // R2
  end
endmodule

// File: rtl/ola_join.sv
module ola_join #(
  parameter int SEG_LEN = 128,
  parameter int RES_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         ret_valid,
  output logic [1:0]         ret_ready,
  input  logic [2*RES_W-1:0] ret_data,
  output logic               out_valid,
  output logic [RES_W:0]     out_data
);
  localparam int CW = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;

  function automatic logic [RES_W:0] ola_add(input logic [RES_W-1:0] a,
                                             input logic [RES_W-1:0] b);
    return {a[RES_W-1], a} + {b[RES_W-1], b};
  endfunction

  logic             ph   [2];    // 0: head half, 1: tail half
  logic [CW-1:0]    cnt  [2];
  logic             hsel, tsel;
  logic [RES_W-1:0] ovl  [SEG_LEN];
  logic             full [SEG_LEN];

  // named events
  logic [CW-1:0]    hidx, tidx;
  logic [RES_W-1:0] head_v, tail_in, tail_v;
  logic             tail_wr, head_rd, hit;

  always_comb begin
    hidx    = cnt[hsel];
    tidx    = cnt[tsel];
    head_v  = hsel ? ret_data[2*RES_W-1:RES_W] : ret_data[RES_W-1:0];
    tail_in = tsel ? ret_data[2*RES_W-1:RES_W] : ret_data[RES_W-1:0];
    tail_wr = ret_valid[tsel] & ph[tsel] & ~full[tidx];
    hit     = tail_wr & (tidx == hidx);
    head_rd = ret_valid[hsel] & ~ph[hsel] & (full[hidx] | hit);
    tail_v  = full[hidx] ? ovl[hidx] : tail_in;
    for (int p = 0; p < 2; p++)
      ret_ready[p] = ph[p] ? (tsel == 1'(p) && tail_wr) : (hsel == 1'(p) && head_rd);
  end

  assign out_valid = head_rd;
  assign out_data  = ola_add(head_v, tail_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsel <= ola_pkg::PATH_EVEN;
      tsel <= ola_pkg::PATH_EVEN;
      for (int p = 0; p < 2; p++) begin
        ph[p]  <= 1'b0;
        cnt[p] <= '0;
      end
      for (int j = 0; j < SEG_LEN; j++) begin
        ovl[j]  <= '0;
        full[j] <= 1'b1;  // zero tail counts as present
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (ret_valid[p] && ret_ready[p]) begin
          cnt[p] <= cnt[p] + 1'b1;
          if (ola_pkg::is_last(int'(cnt[p]), SEG_LEN)) ph[p] <= ~ph[p];
        end
      end
      if (head_rd && ola_pkg::is_last(int'(hidx), SEG_LEN)) hsel <= ~hsel;
      if (tail_wr && ola_pkg::is_last(int'(tidx), SEG_LEN)) tsel <= ~tsel;
      for (int j = 0; j < SEG_LEN; j++) begin
        if (head_rd && hidx == CW'(j)) begin
          full[j] <= 1'b0;
        end else if (tail_wr && tidx == CW'(j)) begin
          full[j] <= 1'b1;
          ovl[j]  <= tail_in;
        end
      end
    end
  end

  AST_HEAD_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (head_rd && hidx == CW'(SEG_LEN - 1)) |=> (hsel != $past(hsel)));  // R5

  AST_TAIL_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_wr && tidx == CW'(SEG_LEN - 1)) |=> (tsel != $past(tsel)));  // R5

  AST_SLOT_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_wr && !hit) |=> full[$past(tidx)]);  // R5
endmodule

// File: rtl/ola_sched.sv
module ola_sched #(
  parameter int SEG_LEN = 128,
  parameter int DATA_W  = 12,
  parameter int RES_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  output logic                seg_sel,
  output logic [1:0]          fr_valid,
  output logic [1:0]          fr_start,
  output logic [2*DATA_W-1:0] fr_data,
  input  logic [1:0]          ret_valid,
  output logic [1:0]          ret_ready,
  input  logic [2*RES_W-1:0]  ret_data,
  output logic                out_valid,
  output logic [RES_W:0]      out_data
);
  seg_sched #(.SEG_LEN(SEG_LEN), .DATA_W(DATA_W)) u_sched (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .seg_sel(seg_sel), .fr_valid(fr_valid), .fr_start(fr_start), .fr_data(fr_data)
  );

  ola_join #(.SEG_LEN(SEG_LEN), .RES_W(RES_W)) u_join (
    .clk(clk), .rst_n(rst_n),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_data(ret_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid[0] && ret_valid[1]) |-> (ret_ready != 2'b00));  // R7
endmodule

// File: tb/ola_sched_tb.sv
`timescale 1ns/1ps
module ola_sched_tb;
  localparam int N    = 8;
  localparam int DW   = 12;
  localparam int RW   = 24;
  localparam int MAXL = 2 * N;
  localparam int K    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic seg_sel;
  logic [1:0] fr_valid, fr_start;
  logic [2*DW-1:0] fr_data;
  logic [1:0] ret_valid, ret_ready;
  logic [2*RW-1:0] ret_data;
  logic out_valid;
  logic [RW:0] out_data;

  always #5 clk = ~clk;

  ola_sched #(.SEG_LEN(N), .DATA_W(DW), .RES_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .seg_sel(seg_sel), .fr_valid(fr_valid), .fr_start(fr_start), .fr_data(fr_data),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_data(ret_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  int h [N] = '{4, -3, 2, 0, 1, 0, -1, 3};
  int xs [K*N];
  int lat_sel = 1;
  int gap_on = 0;
  bit run_on = 0;
  int acc = 0;
  int ocnt = 0;
  int padx [2];

  // ---------------- path stubs: FIR over each frame, fixed latency ----------------
  logic [1:0] dv [MAXL];
  int dd [2][MAXL];
  int hist [2][N];
  int sx, sy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAXL; i++) dv[i] <= '0;
      for (int p = 0; p < 2; p++) for (int m = 0; m < N; m++) hist[p][m] <= 0;
    end else begin
      for (int i = MAXL - 1; i > 0; i--) begin
        dv[i] <= dv[i-1];
        dd[0][i] <= dd[0][i-1];
        dd[1][i] <= dd[1][i-1];
      end
      dv[0] <= fr_valid;
      for (int p = 0; p < 2; p++) begin
        if (fr_valid[p]) begin
          sx = (p == 1) ? int'($signed(fr_data[2*DW-1:DW])) : int'($signed(fr_data[DW-1:0]));
          sy = h[0] * sx;
          for (int m = 1; m < N; m++) sy += h[m] * (fr_start[p] ? 0 : hist[p][m-1]);
          dd[p][0] <= sy;
          hist[p][0] <= sx;
          for (int m = 1; m < N; m++) hist[p][m] <= fr_start[p] ? 0 : hist[p][m-1];
        end
      end
    end
  end

  always_comb begin
    ret_valid = dv[lat_sel-1];
    ret_data  = {dd[1][lat_sel-1][RW-1:0], dd[0][lat_sel-1][RW-1:0]};
  end

  function automatic int conv_at(int n);
    int s = 0;
    for (int m = 0; m < N; m++) if (n - m >= 0) s += h[m] * xs[n-m];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (lat=%0d gap=%0d)", req, act, exp, lat_sel, gap_on);
    end
  endtask

  // ---------------- monitor, sampled on the falling edge ----------------
  always @(negedge clk) begin
    int p;
    int e;
    if (rst_n && run_on) begin
      for (int q = 0; q < 2; q++) begin
        if (padx[q] > 0) begin   // R4 zero tail
          chk(fr_valid[q] && fr_data[q*DW +: DW] == '0 && !fr_start[q], "R4",
              int'(fr_valid[q]), 1);
          padx[q]--;
        end
      end
      if (in_valid && in_ready) begin
        p = (acc / N) % 2;
        chk(seg_sel == 1'(p), "R3", int'(seg_sel), p);
        chk(fr_valid[p] && fr_data[p*DW +: DW] == in_data, "R2",
            int'(fr_data[p*DW +: DW]), int'(in_data));
        chk(fr_start[p] == ((acc % N) == 0), "R2", int'(fr_start[p]), int'((acc % N) == 0));
        if ((acc % N) == N - 1) padx[p] = N;
        acc++;
      end
      if (out_valid) begin
        e = conv_at(ocnt);
        if (ocnt < N)
          chk(int'($signed(out_data)) == e, "R6", int'($signed(out_data)), e);
        else if (gap_on != 0)
          chk(int'($signed(out_data)) == e, "R8", int'($signed(out_data)), e);
        else
          chk(int'($signed(out_data)) == e, "R5", int'($signed(out_data)), e);
        ocnt++;
      end
      for (int q = 0; q < 2; q++)
        if (ret_valid[q] && !ret_ready[q]) chk(1'b0, "R7", 0, 1);
    end
  end

  task automatic run(input int lat, input int gap, input int r);
    bit sent;
    int w;
    run_on   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    lat_sel  = lat;
    gap_on   = gap;
    acc = 0; ocnt = 0; padx[0] = 0; padx[1] = 0;
    for (int i = 0; i < K*N; i++) xs[i] = ((i * 389 + r * 1021 + 7) % 4096) - 2048;
    xs[3] = -2048;
    xs[5] = 2047;
    xs[N+2] = -2048;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(fr_valid == 2'b00, "R1", int'(fr_valid), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    chk(seg_sel == 1'b0, "R1", int'(seg_sel), 0);
    run_on = 1;
    @(posedge clk); #1;
    for (int i = 0; i < K*N; i++) begin
      if (gap != 0 && (i % 3) == 2) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_data  = xs[i][DW-1:0];
      sent = 0;
      while (!sent) begin
        @(negedge clk);
        sent = in_ready;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
    w = 0;
    while (ocnt < K*N && w < 500) begin
      @(posedge clk);
      w++;
    end
    repeat (N + 2) @(posedge clk);
    @(negedge clk);
    chk(ocnt == K*N, "R7", ocnt, K*N);
    run_on = 0;
  endtask

  initial begin
    run(1, 0, 0);
    run(3, 1, 1);
    run(MAXL, 0, 2);
    run(MAXL, 1, 3);
    run(7, 1, 4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL R7 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule